// File: doc/BRIEF.md
# Round-Robin Serial ADC Scan Master

This block is the host side of a four-wire serial link to a seven-input, 12-bit successive-approximation converter. It keeps the converter busy by scanning a chosen subset of the inputs in turn. It derives the serial clock from the system clock and frames each 16-clock exchange with an active-low select. Over the data-out line it sends a command byte naming the input for the following conversion. Over the data-in line it gathers the result of the conversion now under way. Each 12-bit result is presented on a valid/ready stream together with the number of the input it was taken from.

The converter always converts the input named one exchange earlier. The tag on each result therefore trails the address being sent by one frame. Out of reset the converter is assumed to point at input 1, so the first result is tagged with code 0. Software sets the input mask, a run control and the serial clock half-period in system clocks. While results are consumed as soon as they appear, the select line stays low from frame to frame. If the consumer stalls, the current frame is completed and the select line is raised until the result is taken.

Top module: `adc_scan_master`

## Requirements
- R1: Out of reset `cs_n` and `sclk` are high, `res_valid` and `frame_err` are low. No frame begins unless `run` is high and at least one bit of `chan_mask` is set.
- R2: Inside a frame every low phase of `sclk` lasts exactly `half_div` system clocks (0 acts as 1), and no high phase is shorter than that. `sclk` is high whenever `cs_n` is high, so the first serial edge after the select falls is a falling edge.
- R3: A frame has 16 `sclk` rising edges. `mosi` changes only away from rising edges. The 16 bits sent MSB first hold the next input code in positions 13:11 of the word (bits 5:3 of the leading command byte), and every other bit is zero.
- R4: `miso` is sampled on each `sclk` rising edge, MSB first. `res_data` holds the last 12 of the 16 bits received.
- R5: Input codes are issued in ascending order among the set bits of `chan_mask` and wrap past the highest. Code 7 is never sent. Code n selects input n+1.
- R6: `res_chan` equals the code sent in the frame before the one that carried the result. The first result after reset is tagged 0.
- R7: With `run` high and `res_ready` high, `cs_n` stays low from one frame to the next.
- R8: While `res_valid` is high and `res_ready` low, `res_data` and `res_chan` stay steady. `cs_n` is high from the second such cycle on, and no new frame starts until the result is taken.
- R9: Dropping `run` lets the frame in progress finish and deliver its result, after which the block goes idle with `cs_n` high. Every conversion that starts yields exactly one result.
- R10: If any of the four leading received bits of a frame is non-zero, `frame_err` rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Scan enable; frames start while high |
| chan_mask | input | NUM_CH | One bit per input, bit n enables code n |
| half_div | input | DIV_W | Serial clock half-period in system clocks |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Command bits to the converter |
| miso | input | 1 | Result bits from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 12 | Straight-binary conversion result |
| res_chan | output | 3 | Input code the result was taken from |
| frame_err | output | 1 | Sticky leading-bit error flag |

## Verification
A result becomes valid at the system clock edge that raises `sclk` for the sixteenth time in its frame. With half-period h, that edge falls 32·h clocks after launch. The converter model and the result collector act on the opposite clock edge, and run lengths are waited out by result counts rather than fixed delays. Serial phase widths are measured in system clocks against `half_div`. The stall checks begin two cycles after `res_valid` rises, which covers the one hold cycle in which the select is still low. The idle checks wait a full frame of 33·h plus margin after `run` drops.

// File: rtl/adc_scan_pkg.sv
// Shared constants, state type and command-word builder for the scan master.
// Assumes a 16-bit exchange: 4 header bits then a 12-bit result.
package adc_scan_pkg;
    localparam int FRAME_LEN = 16;
    localparam int HDR_LEN   = 4;
    localparam int RES_W     = FRAME_LEN - HDR_LEN;
    localparam int ADDR_W    = 3;
    localparam int CMD_LEN   = 8;
    localparam int ADDR_LSB  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_HOLD
    } scan_st_e;

    // Builds the outgoing word: input code at command-byte bits 5:3, zeros elsewhere.
    function automatic logic [FRAME_LEN-1:0] cmd_word(input logic [ADDR_W-1:0] code);
        logic [FRAME_LEN-1:0] w;
        w = '0;
        w[FRAME_LEN-CMD_LEN+ADDR_LSB +: ADDR_W] = code;
        return w;
    endfunction
endpackage

// File: rtl/scan_sclk_div.sv
// Half-period timer for the serial clock. Emits one tick every half_div system
// clocks while enabled; a setting of 0 is treated as 1. Restarts when disabled.
module scan_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;

    // Clamp the half-period to at least one clock.
    assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick     = en && (cnt_q == half_eff - DIV_W'(1));

    // Count system clocks within the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    // R2: the counter never runs past the programmed half-period.
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt_q < half_eff);
endmodule

// File: rtl/scan_chan_pick.sv
// Picks the next enabled input after cur, ascending with wrap-around.
// Assumes cur < NUM_CH; returns cur when only cur is enabled or mask is empty.
module scan_chan_pick #(
    parameter int NUM_CH = 7,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [NUM_CH-1:0] mask,
    output logic [ADDR_W-1:0] nxt,
    output logic              any_en
);
    // Scan offsets from far to near so the nearest enabled input wins.
    always_comb begin
        nxt = cur;
        for (int k = NUM_CH; k >= 1; k--) begin
            int s;
            s = int'(cur) + k;
            if (s >= NUM_CH)
                s = s - NUM_CH;
            if (mask[s])
                nxt = ADDR_W'(s);
        end
    end

    assign any_en = |mask;
endmodule

// File: rtl/adc_scan_master.sv
// Host-side scan master for a 16-clock serial converter exchange.
// Sends the next input code while receiving the current result; tags each
// result with the code sent one frame earlier. Assumes the converter powers
// up pointing at code 0 and idles SCLK high with CS high.
module adc_scan_master
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic [DIV_W-1:0]  half_div,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [RES_W-1:0]  res_data,
    output logic [ADDR_W-1:0] res_chan,
    output logic              frame_err
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

    scan_st_e             st_q;
    logic                 cs_n_q, sclk_q;
    logic [FRAME_LEN-1:0] tx_q, rx_q, rx_next;
    logic [CNT_W-1:0]     bit_q;
    logic [ADDR_W-1:0]    addr_q, tag_q, nxt_addr;
    logic                 any_en, tick, launch;
    logic                 res_valid_q, err_q;
    logic [RES_W-1:0]     res_data_q;
    logic [ADDR_W-1:0]    res_chan_q;

    scan_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(st_q == ST_XFER),
        .half_div(half_div), .tick(tick)
    );

    scan_chan_pick #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_pick (
        .cur(addr_q), .mask(chan_mask), .nxt(nxt_addr), .any_en(any_en)
    );

    // Shift register input after the current sample.
    assign rx_next = {rx_q[FRAME_LEN-2:0], miso};

    // A frame starts from idle with an empty slot, or straight after a frame
    // when the fresh result is taken in the same cycle.
    assign launch = run && any_en &&
                    (((st_q == ST_IDLE) && !res_valid_q) ||
                     ((st_q == ST_HOLD) && res_ready));

    // Frame sequencing, serial shifting and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cs_n_q      <= 1'b1;
            sclk_q      <= 1'b1;
            tx_q        <= '0;
            rx_q        <= '0;
            bit_q       <= '0;
            addr_q      <= '0;
            tag_q       <= '0;
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
            res_chan_q  <= '0;
            err_q       <= 1'b0;
        end else begin
            if (res_valid_q && res_ready)
                res_valid_q <= 1'b0;
            if (launch) begin
                st_q   <= ST_XFER;
                cs_n_q <= 1'b0;
                tx_q   <= cmd_word(nxt_addr);
                addr_q <= nxt_addr;
                tag_q  <= addr_q;
                bit_q  <= '0;
            end else begin
                case (st_q)
                    ST_XFER: if (tick) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            if (bit_q != '0)
                                tx_q <= {tx_q[FRAME_LEN-2:0], 1'b0};
                        end else begin
                            sclk_q <= 1'b1;
                            rx_q   <= rx_next;
                            bit_q  <= bit_q + CNT_W'(1);
                            if (bit_q == LAST_BIT) begin
                                st_q        <= ST_HOLD;
                                res_valid_q <= 1'b1;
                                res_data_q  <= rx_next[RES_W-1:0];
                                res_chan_q  <= tag_q;
                                if (rx_next[FRAME_LEN-1 -: HDR_LEN] != '0)
                                    err_q <= 1'b1;
                            end
                        end
                    end
                    ST_HOLD: begin
                        st_q   <= ST_IDLE;
                        cs_n_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sclk      = sclk_q;
    assign cs_n      = cs_n_q;
    assign mosi      = tx_q[FRAME_LEN-1];
    assign res_valid = res_valid_q;
    assign res_data  = res_data_q;
    assign res_chan  = res_chan_q;
    assign frame_err = err_q;

    // R2: serial clock rests high whenever the select is high.
    assert_sclk_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    // R3: data-out is steady across every rising serial edge.
    assert_mosi_stable_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    // R5: the address register never holds the grounded code or an absent input.
    assert_no_gnd_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER) |-> (addr_q != 3'b111) && (int'(addr_q) < NUM_CH));
    // R8: an unaccepted result is held unchanged.
    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> res_valid && $stable(res_data) && $stable(res_chan));
    // R8: the select is high while a result waits beyond its first cycle.
    assert_cs_high_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(res_valid && !res_ready)) |-> cs_n);
    // R10: the framing error flag never clears outside reset.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);
endmodule

// File: tb/adc_scan_master_bench.sv
module adc_scan_master_bench;
    localparam int NCH = 7;
    localparam int DW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [NCH-1:0] mask = '0;
    logic [DW-1:0] hdiv = 8'd2;
    logic res_ready = 1'b0;
    logic sclk, cs_n, mosi, res_valid, frame_err;
    logic miso = 1'b0;
    logic [11:0] res_data;
    logic [2:0] res_chan;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    adc_scan_master #(.NUM_CH(NCH), .DIV_W(DW)) u_adc_scan_master (
        .clk(clk), .rst_n(rst_n), .run(run), .chan_mask(mask), .half_div(hdiv),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_chan(res_chan), .frame_err(frame_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // ---- converter model ----
    logic [2:0]  dev_addr = 3'd0;
    logic [15:0] dword = '0;
    logic [15:0] din_sh = '0;
    int rcnt = 0;
    int devk = 0;
    bit bad_once = 1'b0;

    task automatic latch_conv();
        dword = {(bad_once ? 4'b0010 : 4'b0000), dev_addr, devk[8:0]};
        bad_once = 1'b0;
        devk++;
    endtask

    always @(negedge cs_n) begin
        latch_conv();
        rcnt = 0;
        miso = dword[15];
    end

    always @(negedge sclk) if (cs_n === 1'b0) begin
        if (rcnt == 16) begin
            latch_conv();
            rcnt = 0;
        end
        miso = dword[15-rcnt];
    end

    always @(posedge sclk) if (cs_n === 1'b0) begin
        din_sh = {din_sh[14:0], mosi};
        rcnt++;
        if (rcnt == 8) begin
            dev_addr = din_sh[5:3];
            chk(din_sh[7:6] == 2'b00 && din_sh[2:0] == 3'b000, "R3 cmd spare bits",
                int'(din_sh[7:0]), int'({2'b00, din_sh[5:3], 3'b000}));
            chk(din_sh[5:3] != 3'b111, "R5 ground code", int'(din_sh[5:3]), 0);
        end
        if (rcnt == 16)
            chk(din_sh[7:0] == 8'h00, "R3 trailing bits", int'(din_sh[7:0]), 0);
    end

    // ---- result collector with independent expected sequence ----
    int rcv = 0;
    logic [2:0] exp_tag = 3'd0;

    function automatic logic [2:0] next_code(input logic [2:0] cur, input logic [NCH-1:0] m);
        for (int k = 1; k <= NCH; k++) begin
            int idx;
            idx = (int'(cur) + k) % NCH;
            if (m[idx]) return 3'(idx);
        end
        return cur;
    endfunction

    always @(negedge clk) if (rst_n && res_valid && res_ready) begin
        chk(res_chan == exp_tag, "R5 R6 tag", int'(res_chan), int'(exp_tag));
        chk(res_data == {exp_tag, 9'(rcv)}, "R4 data", int'(res_data),
            int'({exp_tag, 9'(rcv)}));
        exp_tag = next_code(exp_tag, mask);
        rcv++;
    end

    // ---- serial clock and select monitors ----
    int lo_run = 0, hi_run = 0, lo_bad = 0, hi_bad = 0, lo_seen = 0, idle_bad = 0;
    int cs_rises = 0;
    logic cs_prev = 1'b1;

    always @(negedge clk) if (rst_n) begin
        if (cs_n && !sclk) idle_bad++;
        if (!cs_n && !sclk) begin
            lo_run++;
            if (hi_run > 0 && hi_run < int'(hdiv)) hi_bad++;
            hi_run = 0;
        end else begin
            if (lo_run > 0) begin
                if (lo_run != int'(hdiv)) lo_bad++;
                lo_seen++;
            end
            lo_run = 0;
            if (!cs_n) hi_run++; else hi_run = 0;
        end
        if (cs_n && !cs_prev) cs_rises++;
        cs_prev = cs_n;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 180000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic drive_step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_results(input int target);
        while (rcv < target) @(negedge clk);
    endtask

    // R9: drop run, wait a full frame, expect idle and one result per conversion.
    task automatic stop_run();
        drive_step();
        run = 1'b0;
        repeat (40 * int'(hdiv) + 10) @(negedge clk);
        chk(cs_n && !res_valid, "R9 idle after stop", int'({cs_n, res_valid}), 2);
        chk(devk == rcv, "R9 results per conversion", rcv, devk);
    endtask

    task automatic scan(input logic [NCH-1:0] m, input int n);
        int base;
        base = rcv;
        drive_step();
        mask = m;
        run = 1'b1;
        wait_results(base + n);
        stop_run();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk === 1'b1, "R1 sclk", int'(sclk), 1);
        chk(res_valid === 1'b0, "R1 res_valid", int'(res_valid), 0);
        chk(frame_err === 1'b0, "R1 frame_err", int'(frame_err), 0);

        // R1: empty mask never starts a frame
        drive_step();
        res_ready = 1'b1;
        run = 1'b1;
        repeat (200) @(negedge clk);
        chk(cs_rises == 0 && cs_n && devk == 0, "R1 empty mask", devk, 0);
        drive_step();
        run = 1'b0;

        // R7: continuous scan keeps select low
        begin
            int base;
            base = rcv;
            drive_step();
            mask = 7'h7F;
            run = 1'b1;
            @(negedge cs_n);
            cs_rises = 0;
            wait_results(base + 10);
            chk(cs_rises == 0, "R7 select stays low", cs_rises, 0);
            stop_run();
        end

        // R5 R6: sweep every non-empty mask
        for (int m = 1; m < 128; m++)
            scan(7'(m), 3);

        // R2: divider settings
        for (int h = 1; h <= 5; h += 2) begin
            drive_step();
            hdiv = 8'(h);
            lo_bad = 0; hi_bad = 0; lo_seen = 0;
            scan(7'h7F, 4);
            chk(lo_bad == 0 && lo_seen > 0, "R2 low phase width", lo_bad, 0);
            chk(hi_bad == 0, "R2 high phase width", hi_bad, 0);
        end
        chk(idle_bad == 0, "R2 idle high", idle_bad, 0);

        // R8: back-pressure
        begin
            logic [11:0] held;
            int bp_bad;
            bp_bad = 0;
            drive_step();
            hdiv = 8'd2;
            mask = 7'h7F;
            res_ready = 1'b0;
            run = 1'b1;
            while (!res_valid) @(negedge clk);
            held = res_data;
            repeat (2) @(negedge clk);
            repeat (300) begin
                @(negedge clk);
                if (!cs_n || !res_valid || res_data != held) bp_bad++;
            end
            chk(bp_bad == 0, "R8 stall holds", bp_bad, 0);
            chk(devk == rcv + 1, "R8 no new frame", devk, rcv + 1);
            drive_step();
            res_ready = 1'b1;
            wait_results(rcv + 3);
            stop_run();
        end

        // R10: header error is flagged and sticky
        chk(frame_err == 1'b0, "R10 clear before", int'(frame_err), 0);
        bad_once = 1'b1;
        scan(7'h15, 3);
        chk(frame_err == 1'b1, "R10 raised", int'(frame_err), 1);
        scan(7'h7F, 2);
        chk(frame_err == 1'b1, "R10 sticky", int'(frame_err), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule